// File: doc/BRIEF.md
# Sticky Edge-Triggered Interrupt Controller

This block watches a vector of raw event lines and records each rising edge in a sticky status register. A per-bit mask register decides which recorded events may pull the active-low interrupt line. The host reads the status vector while pulsing a read strobe. It writes the mask through a write strobe.

A read has two effects on each bit. It always withdraws that bit's claim on the interrupt. It clears the status bit only if the raw line has already dropped. A line that stays high after a read keeps its status bit set but cannot assert the interrupt again until it falls and rises. A bit recorded while masked and not yet read raises the interrupt as soon as it is unmasked.

Each bit is tracked by its own three-state machine:
- `ST_IDLE`: status clear.
- `ST_PEND`: status set and not yet read, so it may drive the interrupt.
- `ST_SEEN`: status set and already read, with the raw line still high or not yet re-read.

The transitions are:
- `IDLE->PEND` on a rising edge.
- `PEND->SEEN` on a read while the line is high.
- `PEND->IDLE` on a read while the line is low.
- `SEEN->IDLE` on a read while the line is low.
- `SEEN->PEND` on a new rising edge.
- `PEND->PEND` on a rising edge, which takes priority over a read in the same cycle.

Software is expected to read the status once after reset. This clears events that occurred while the sources were starting up.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A rising edge on `evt_raw[i]` (low in one sampled cycle, high in the next) sets status bit i one clock later. Without a read, the bit stays set whatever the raw line does.
- R2: A rising edge on a bit whose mask bit is 1 sets its status bit. `irq_n` stays high.
- R3: A rising edge on a bit whose mask bit is 0 sets its status bit. It also drives `irq_n` low on the same clock.
- R4: Consider a read strobe on a clock where `evt_raw[i]` is low. On that clock, status bit i clears and stops holding `irq_n` low. `irq_n` remains low until every set, unmasked bit has been read.
- R5: Consider a read strobe on a clock where `evt_raw[i]` is high. Status bit i stays set, but it no longer holds `irq_n` low. A line that stays high does not assert `irq_n` again. A later fall and rise does assert it again.
- R6: Writing a mask with bit i equal to 0 drives `irq_n` low one clock after the write when bit i is set and unread. When bit i was already read, the same write leaves `irq_n` high.
- R7: Suppose a rising edge on bit i arrives on the same clock as a read strobe. The edge wins: bit i stays set and unread, and it still drives `irq_n` when unmasked.
- R8: Reset (`rst_n` low, asynchronous) clears all status bits and the edge history, sets the mask to all ones, and holds `irq_n` high. A line that is high when reset is released counts as a rising edge on the first clock.
- R9: `rd_data` always shows the current status vector, so its value in the cycle of the read strobe is what the host reads. Bit i of `rd_data` is status bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_raw | input | N_EVT | Raw event lines, synchronous to clk |
| rd_en | input | 1 | Status read strobe, one cycle per read |
| rd_data | output | N_EVT | Current status vector |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | N_EVT | New mask value; 1 = masked |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Each bit's state becomes visible one clock after the edge that produced it. A state machine stuck in or wrongly entering `ST_IDLE` shows as a missing or stray `rd_data` bit. A wrong split between `ST_PEND` and `ST_SEEN` shows as `irq_n` held low after a read, or failing to fall on unmask or on a fresh edge. The bench therefore samples both outputs on the cycle after every edge, read, mask write and reset release. It covers a read colliding with an edge and a line held high across a read.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Per-bit tracking state: clear, set-and-unread, set-and-read.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_SEEN = 2'd2
    } bit_state_e;

endpackage

// File: rtl/evt_irq_slice.sv
module evt_irq_slice
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic rd_i,
    output logic stat_o,
    output logic pend_o
);

    logic       hist_q;
    logic       rise;
    bit_state_e state_q;
    bit_state_e state_d;

    assign rise = raw_i & ~hist_q;

    // state register and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q  <= 1'b0;
            state_q <= ST_IDLE;
        end else begin
            hist_q  <= raw_i;
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rise) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (rise)      state_d = ST_PEND;
                else if (rd_i) state_d = raw_i ? ST_SEEN : ST_IDLE;
            end
            ST_SEEN: begin
                if (rise)               state_d = ST_PEND;
                else if (rd_i && !raw_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        stat_o = 1'b0;
        pend_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                stat_o = 1'b0;
                pend_o = 1'b0;
            end
            ST_PEND: begin
                stat_o = 1'b1;
                pend_o = 1'b1;
            end
            ST_SEEN: begin
                stat_o = 1'b1;
                pend_o = 1'b0;
            end
            default: begin
                stat_o = 1'b0;
                pend_o = 1'b0;
            end
        endcase
    end

    p_rise_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (stat_o && pend_o));

    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && !rd_i) |=> stat_o);

    p_read_low_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !raw_i) |=> !stat_o);

    p_read_high_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && raw_i && stat_o) |=> stat_o);

    p_read_unpends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !rise) |=> !pend_o);

    p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && rise) |=> pend_o);

endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] mask_o
);

    localparam logic [WIDTH-1:0] RESET_MASK = {WIDTH{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mask_o <= RESET_MASK;
        else if (wr_i) mask_o <= wdata_i;
    end

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));

endmodule

// File: rtl/evt_irq_merge.sv
module evt_irq_merge #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] pend_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             irq_n_o
);

    logic [WIDTH-1:0] live;

    always_comb begin
        live    = pend_i & ~mask_i;
        irq_n_o = ~(|live);
    end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
    parameter int unsigned N_EVT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_raw,
    input  logic             rd_en,
    output logic [N_EVT-1:0] rd_data,
    input  logic             mask_wr,
    input  logic [N_EVT-1:0] mask_wdata,
    output logic             irq_n
);

    logic [N_EVT-1:0] stat_vec;
    logic [N_EVT-1:0] pend_vec;
    logic [N_EVT-1:0] mask_vec;

    for (genvar g = 0; g < N_EVT; g++) begin : g_bit
        evt_irq_slice u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (evt_raw[g]),
            .rd_i   (rd_en),
            .stat_o (stat_vec[g]),
            .pend_o (pend_vec[g])
        );
    end

    evt_irq_mask #(.WIDTH(N_EVT)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr),
        .wdata_i (mask_wdata),
        .mask_o  (mask_vec)
    );

    evt_irq_merge #(.WIDTH(N_EVT)) u_merge (
        .pend_i  (pend_vec),
        .mask_i  (mask_vec),
        .irq_n_o (irq_n)
    );

    assign rd_data = stat_vec;

    // unmasking a set, unread bit raises the interrupt next clock
    p_unmask_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !rd_en && |(pend_vec & ~mask_wdata)) |=> !irq_n);

    // with everything masked the line never falls
    p_all_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_vec) |-> irq_n);

    // reset state seen at the ports
    always_comb begin
        if (!rst_n) begin
            a_reset_outputs_r8: assert (irq_n && (rd_data == '0));
        end
    end

endmodule

// File: tb/evt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_raw = '0;
    logic         rd_en = 1'b0;
    logic [N-1:0] rd_data;
    logic         mask_wr = 1'b0;
    logic [N-1:0] mask_wdata = '0;
    logic         irq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    evt_irq_ctrl #(.N_EVT(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_raw(evt_raw), .rd_en(rd_en),
        .rd_data(rd_data), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_read(input string tag, input logic [N-1:0] exp);
        rd_en = 1'b1;
        #1;
        chk(tag, rd_data, exp);
        cyc();
        rd_en = 1'b0;
    endtask

    task automatic wr_mask(input logic [N-1:0] m);
        mask_wr = 1'b1;
        mask_wdata = m;
        cyc();
        mask_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R8 status after reset", rd_data, 8'h00);
        chk("R8 irq_n after reset", irq_n, 1'b1);
    endtask

    task automatic t_masked;
        evt_raw = 8'h01; cyc();
        chk("R2 masked edge sets status", rd_data, 8'h01);
        chk("R2 masked edge irq_n high", irq_n, 1'b1);
        evt_raw = 8'h00; cyc();
        chk("R1 status sticky after fall", rd_data, 8'h01);
        do_read("R9 read data masked", 8'h01);
        chk("R4 read with line low clears", rd_data, 8'h00);
    endtask

    task automatic t_unmasked;
        wr_mask(8'hF0);
        evt_raw = 8'h03; cyc();
        chk("R3 unmasked edge irq_n low", irq_n, 1'b0);
        chk("R3 unmasked edge status", rd_data, 8'h03);
        evt_raw = 8'h00; cyc(3);
        chk("R1 irq held after line falls", irq_n, 1'b0);
        do_read("R9 read data two bits", 8'h03);
        chk("R4 irq released after read", irq_n, 1'b1);
        chk("R4 status cleared after read", rd_data, 8'h00);
    endtask

    task automatic t_multi;
        evt_raw = 8'h01; cyc();
        evt_raw = 8'h03; cyc();
        evt_raw = 8'h00; cyc(2);
        chk("R4 irq low until read", irq_n, 1'b0);
        do_read("R4 read both", 8'h03);
        chk("R4 irq high after all read", irq_n, 1'b1);
    endtask

    task automatic t_level;
        evt_raw = 8'h04; cyc();
        chk("R3 level bit irq low", irq_n, 1'b0);
        do_read("R5 read while high", 8'h04);
        chk("R5 status kept while high", rd_data, 8'h04);
        chk("R5 irq released while high", irq_n, 1'b1);
        cyc(3);
        chk("R5 no reassert on steady level", irq_n, 1'b1);
        evt_raw = 8'h00; cyc();
        chk("R5 status kept after fall unread", rd_data, 8'h04);
        chk("R5 irq high after fall", irq_n, 1'b1);
        evt_raw = 8'h04; cyc();
        chk("R5 new rise reasserts", irq_n, 1'b0);
        evt_raw = 8'h00; cyc();
        do_read("R5 final read", 8'h04);
        chk("R5 cleared at end", rd_data, 8'h00);
        chk("R5 irq high at end", irq_n, 1'b1);
    endtask

    task automatic t_unmask;
        wr_mask(8'hFF);
        evt_raw = 8'h10; cyc();
        evt_raw = 8'h00; cyc();
        chk("R6 masked pending irq high", irq_n, 1'b1);
        wr_mask(8'hEF);
        chk("R6 unmask pending raises irq", irq_n, 1'b0);
        do_read("R6 read pending", 8'h10);
        chk("R6 irq high after read", irq_n, 1'b1);
        evt_raw = 8'h20; cyc();
        do_read("R6 read masked high bit", 8'h20);
        wr_mask(8'hCF);
        chk("R6 unmask read bit no irq", irq_n, 1'b1);
        chk("R6 read bit still set", rd_data, 8'h20);
        evt_raw = 8'h00; cyc();
        do_read("R6 cleanup read", 8'h20);
        chk("R6 cleaned", rd_data, 8'h00);
    endtask

    task automatic t_collide;
        wr_mask(8'hF0);
        evt_raw = 8'h01; cyc();
        evt_raw = 8'h03;
        do_read("R7 read on colliding edge", 8'h01);
        chk("R7 both bits set after collision", rd_data, 8'h03);
        chk("R7 new edge holds irq", irq_n, 1'b0);
        evt_raw = 8'h00; cyc();
        do_read("R7 second read", 8'h03);
        chk("R7 cleared", rd_data, 8'h00);
        chk("R7 irq released", irq_n, 1'b1);
    endtask

    task automatic t_reset_edge;
        rst_n = 1'b0;
        evt_raw = 8'h80;
        cyc(2);
        chk("R8 status held clear in reset", rd_data, 8'h00);
        chk("R8 irq high in reset", irq_n, 1'b1);
        rst_n = 1'b1; cyc();
        chk("R8 high line at release is an edge", rd_data, 8'h80);
        chk("R8 mask all ones after reset", irq_n, 1'b1);
        wr_mask(8'h7F);
        chk("R8 unmask startup event raises irq", irq_n, 1'b0);
        evt_raw = 8'h00; cyc();
        do_read("R8 startup clear read", 8'h80);
        chk("R8 clear after startup read", rd_data, 8'h00);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_masked();
        t_unmasked();
        t_multi();
        t_level();
        t_unmask();
        t_collide();
        t_reset_edge();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule